// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves an 18-bit word between two ports, A and B, over two independent one-way paths. Each path has three controls: a direction enable, a pass control and a capture clock. While its pass control is high, a path copies its input to the opposite port with no register in between. While the pass control is low, the path shows a stored word. That word changes only when the capture clock rises. Otherwise the path holds it and ignores its input.

Each port is modelled as a tri-state pin group with three parts: an input vector, an output data vector and an enable vector, one enable bit per pin. The A-to-B enable is active high. The B-to-A enable is active low. Storage keeps working while a port is disabled, so re-enabling the port shows the word held at that moment. The system clock samples the capture clocks, which must be synchronous to it. Reset is an active-low asynchronous input that is released synchronously, and it clears both stored words.

Top module: `regbus_xcvr`

## Requirements
- R1: Both paths are 18 bits wide. After reset, both stored words are zero, so an enabled port with its pass control low shows 0.
- R2: While pass_ab is high, b_out equals a_in in the same cycle and tracks every change of a_in.
- R3: While pass_ab is low and cap_ab stays at one level (high or low), b_out keeps the stored word whatever a_in does.
- R4: While pass_ab is low, a rise of cap_ab (low at one system clock edge, high at the next) loads a_in into storage at that edge, and b_out shows the new word from then on.
- R5: If pass_ab falls while cap_ab is high, b_out keeps the last word passed through. It still holds that word after cap_ab later goes low.
- R6: The A-to-B enable en_ab is active high. While en_ab is low, every bit of b_oe is 0 and b_out reads 0. While en_ab is high, every bit of b_oe is 1.
- R7: The B-to-A enable en_ba_n is active low. While en_ba_n is high, every bit of a_oe is 0 and a_out reads 0. While en_ba_n is low, every bit of a_oe is 1.
- R8: The B-to-A path (b_in, pass_ba, cap_ba, a_out) follows R2 to R5 in the same way, and its activity leaves the A-to-B output unchanged.
- R9: Storage keeps loading while the output port is disabled. When the port is enabled again, it shows the word captured while it was disabled.
- R10: Each port's enable vector depends only on that port's own direction enable. With en_ab high and en_ba_n high, only port B is driven, so a loopback of b_out into b_in causes no bit to be driven from both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the capture clocks |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_in | input | 18 | Data arriving on port A |
| a_out | output | 18 | Data driven onto port A (0 when disabled) |
| a_oe | output | 18 | Per-pin drive enable for port A |
| b_in | input | 18 | Data arriving on port B |
| b_out | output | 18 | Data driven onto port B (0 when disabled) |
| b_oe | output | 18 | Per-pin drive enable for port B |
| en_ab | input | 1 | A-to-B drive enable, active high |
| pass_ab | input | 1 | A-to-B pass control: high passes data, low holds |
| cap_ab | input | 1 | A-to-B capture clock |
| en_ba_n | input | 1 | B-to-A drive enable, active low |
| pass_ba | input | 1 | B-to-A pass control |
| cap_ba | input | 1 | B-to-A capture clock |

## Verification
The assertions check three rules on every cycle for each path. After the pass control falls, the output shows the word that was present at the falling edge. A capture-clock rise with the pass control low loads the input. With no rise, the output stays stable. The assertions also check that every enable vector is all ones or all zeros. Some behaviour only the bench scenarios can show: the zero word after reset, a hold that outlasts a later fall of the capture clock, a capture made while the port is disabled and seen after re-enabling, and the loopback run in which the bench watches for any bit driven from both sides.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int unsigned BUS_W = 18;

  typedef enum logic [1:0] {
    LANE_PASS    = 2'd0,
    LANE_HOLD    = 2'd1,
    LANE_CAPTURE = 2'd2
  } lane_mode_e;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import regbus_pkg::*;
#(
  parameter int unsigned W = BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         pass,
  input  logic         cap,
  output logic [W-1:0] dout
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;
  logic         word_en;
  logic         cap_q;
  logic         cap_rise;
  lane_mode_e   mode;

  // mode and next-state selection
  always_comb begin
    cap_rise = cap & ~cap_q;
    if (pass) begin
      mode = LANE_PASS;
    end else if (cap_rise) begin
      mode = LANE_CAPTURE;
    end else begin
      mode = LANE_HOLD;
    end
    word_en = (mode != LANE_HOLD);
    word_d  = word_en ? din : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cap_q  <= 1'b0;
    end else begin
      cap_q <= cap;
      if (word_en) begin
        word_q <= word_d;
      end
    end
  end

  assign dout = pass ? din : word_q;

  // R5: once the pass control drops, the output keeps what was passing at the edge
  assert_hold_after_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && $past(pass)) |-> (dout == $past(din)));

  // R4: a capture-clock rise with pass low loads the input
  assert_capture_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !$past(pass) && $past(cap) && !$past(cap, 2)) |-> (dout == $past(din)));

  // R3: with pass low and no capture rise, the output does not move
  assert_hold_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !$past(pass) && !($past(cap) && !$past(cap, 2))) |-> $stable(dout));
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int unsigned W          = 18,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic         oe_in,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] data_o,
  output logic [W-1:0] oe_o
);
  logic drive_en;

  generate
    if (ACTIVE_LOW) begin : g_low
      assign drive_en = ~oe_in;
    end else begin : g_high
      assign drive_en = oe_in;
    end
  endgenerate

  always_comb begin
    oe_o   = {W{drive_en}};
    data_o = drive_en ? data_in : '0;
  end

  // R6/R7: the enable vector is uniform across the port
  always_comb begin
    if (!$isunknown(oe_o)) begin
      assert_uniform_oe_R6: assert ((oe_o == '0) || (&oe_o));
    end
  end

  // R7: a disabled port carries no data
  always_comb begin
    if (!$isunknown(oe_o) && !$isunknown(data_o)) begin
      assert_idle_data_R7: assert ((|oe_o) || (data_o == '0));
    end
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_pkg::*;
#(
  parameter int unsigned W = BUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         en_ab,
  input  logic         pass_ab,
  input  logic         cap_ab,
  input  logic         en_ba_n,
  input  logic         pass_ba,
  input  logic         cap_ba
);
  logic         rst_n_sync;
  logic [W-1:0] ab_word;
  logic [W-1:0] ba_word;

  xcvr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  xcvr_lane #(.W(W)) u_lane_ab (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .din   (a_in),
    .pass  (pass_ab),
    .cap   (cap_ab),
    .dout  (ab_word)
  );

  xcvr_lane #(.W(W)) u_lane_ba (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .din   (b_in),
    .pass  (pass_ba),
    .cap   (cap_ba),
    .dout  (ba_word)
  );

  xcvr_drive #(.W(W), .ACTIVE_LOW(1'b0)) u_drive_b (
    .oe_in   (en_ab),
    .data_in (ab_word),
    .data_o  (b_out),
    .oe_o    (b_oe)
  );

  xcvr_drive #(.W(W), .ACTIVE_LOW(1'b1)) u_drive_a (
    .oe_in   (en_ba_n),
    .data_in (ba_word),
    .data_o  (a_out),
    .oe_o    (a_oe)
  );
endmodule

// File: tb/regbus_xcvr_tb.sv
`timescale 1ns/1ps
module regbus_xcvr_tb;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic [W-1:0] b_in_drv;
  logic [W-1:0] b_in;
  logic         en_ab, pass_ab, cap_ab, en_ba_n, pass_ba, cap_ba;
  logic         loop_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign b_in = loop_en ? b_out : b_in_drv;

  regbus_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .en_ab(en_ab), .pass_ab(pass_ab), .cap_ab(cap_ab),
    .en_ba_n(en_ba_n), .pass_ba(pass_ba), .cap_ba(cap_ba)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // advance one system clock; returns just after the falling edge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    en_ab = 1'b1; en_ba_n = 1'b0; settle();
    chk("R1 b_out after reset", b_out, '0);
    chk("R1 a_out after reset", a_out, '0);
    chk("R6 b_oe enabled", b_oe, '1);
    chk("R7 a_oe enabled", a_oe, '1);
  endtask

  task automatic t_transparent();
    step(); pass_ab = 1'b1; a_in = 18'h2A5C3; settle();
    chk("R2 pass first word", b_out, 18'h2A5C3);
    a_in = 18'h1035E; settle();
    chk("R2 pass tracks change", b_out, 18'h1035E);
    step();
  endtask

  task automatic t_capture();
    pass_ab = 1'b0; cap_ab = 1'b0; a_in = 18'h00000; step();
    a_in = 18'h3C0F1; cap_ab = 1'b1; step();
    settle(); chk("R4 captured on rise", b_out, 18'h3C0F1);
    a_in = 18'h0F0F0; step(2);
    settle(); chk("R3 hold with cap high", b_out, 18'h3C0F1);
    cap_ab = 1'b0; a_in = 18'h15555; step(2);
    settle(); chk("R3 hold with cap low", b_out, 18'h3C0F1);
  endtask

  task automatic t_pass_fall_cap_high();
    cap_ab = 1'b1; pass_ab = 1'b1; a_in = 18'h2BEEF; step();
    pass_ab = 1'b0; step();
    a_in = 18'h00123; step();
    settle(); chk("R5 hold after pass fall", b_out, 18'h2BEEF);
    cap_ab = 1'b0; step(2);
    settle(); chk("R5 hold after cap falls", b_out, 18'h2BEEF);
  endtask

  task automatic t_enable_ab();
    en_ab = 1'b0; settle();
    chk("R6 b_oe off", b_oe, '0);
    chk("R6 b_out zero when off", b_out, '0);
    pass_ab = 1'b0; cap_ab = 1'b0; step();
    a_in = 18'h1ACE5; cap_ab = 1'b1; step();
    a_in = 18'h00001; step();
    en_ab = 1'b1; settle();
    chk("R9 capture while disabled", b_out, 18'h1ACE5);
    chk("R6 b_oe back on", b_oe, '1);
  endtask

  task automatic t_path_ba();
    en_ba_n = 1'b1; settle();
    chk("R7 a_oe off", a_oe, '0);
    chk("R7 a_out zero when off", a_out, '0);
    en_ba_n = 1'b0; pass_ba = 1'b1; b_in_drv = 18'h33CC3; settle();
    chk("R8 ba pass", a_out, 18'h33CC3);
    cap_ba = 1'b0; step(); pass_ba = 1'b0; step();
    b_in_drv = 18'h0AAAA; step();
    settle(); chk("R8 ba hold", a_out, 18'h33CC3);
    cap_ba = 1'b1; step();
    settle(); chk("R8 ba capture", a_out, 18'h0AAAA);
    chk("R8 ab unaffected", b_out, 18'h1ACE5);
    cap_ba = 1'b0; step();
  endtask

  task automatic t_loopback();
    en_ab = 1'b1; en_ba_n = 1'b1; pass_ab = 1'b1; pass_ba = 1'b1;
    loop_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      a_in = 18'h01111 * (k + 1);
      settle();
      checks++;
      if ((a_oe & b_oe) != '0) begin
        errors++;
        $display("FAIL R10 overlap actual=%h expected=%h", a_oe & b_oe, 18'h0);
      end
      chk("R10 loopback data on B", b_out, a_in);
      step();
    end
    loop_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; loop_en = 1'b0;
    a_in = '0; b_in_drv = '0;
    en_ab = 1'b0; pass_ab = 1'b0; cap_ab = 1'b0;
    en_ba_n = 1'b1; pass_ba = 1'b0; cap_ba = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_transparent();
    t_capture();
    t_pass_fall_cap_high();
    t_enable_ab();
    t_path_ba();
    t_loopback();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule